// File: doc/BRIEF.md
# Successive-Approximation Converter Scan Sequencer

This block is the digital side of a 10-bit successive-approximation converter shared among up to eight analog inputs. It turns the peripheral clock into a slower conversion rate through a programmable divider. For the channel being converted it drives the input multiplexer select, a sample/hold strobe and the trial code for the internal DAC. It reads back the analog comparator and files each finished result in a per-channel register with a done flag and an overrun flag.

A conversion is one sampling period followed by ten bit decisions, most significant bit first. Software either fires a single conversion with a one-cycle start pulse, or holds the burst enable high so that the block cycles through every selected channel with no gap between conversions. When burst is dropped, the conversion in progress still finishes and its result is stored. The analog multiplexer, sample/hold, DAC and comparator sit outside the block. The divider setting must keep the conversion rate at or below 4.5 MHz, and that limit is a system constraint.

Top module: `sar_scan_ctrl`

## Requirements
- R1: With divider value D latched at the start of a conversion, one conversion period lasts D+1 clock cycles and a whole conversion lasts exactly 11*(D+1) clock cycles.
- R2: `sample_hold` is high for the first D+1 cycles of each conversion and low at all other times.
- R3: `comp_in` = 1 means the held input is at or above `dac_code`. The ten decisions run from bit 9 down to bit 0, and a trial bit is kept only when the comparator reads 1. The stored result is the largest code not above the input, so any input above 1023 gives 1023.
- R4: In burst mode the first conversion uses the lowest set bit of `chan_mask`. Each next conversion uses the next higher set bit, and after the highest set bit the scan returns to the lowest one.
- R5: In burst mode the next conversion begins in the clock cycle right after the last cycle of the previous one, with no idle cycles between them.
- R6: When `burst_en` goes low during a conversion, that conversion completes in full and its result is stored. The block then becomes idle.
- R7: With `chan_mask` all zero, neither `burst_en` nor `start_once` starts a conversion, and `busy` stays low.
- R8: A `start_once` pulse while idle with `burst_en` low performs exactly one conversion, on the lowest selected channel.
- R9: A stored result sets that channel's bit in `done_flags`. `rd_data` shows the result of `rd_chan` combinationally, and `rd_en` clears that channel's done bit at the next clock edge.
- R10: A write to a channel whose done bit is set, with no read of that channel in the same cycle, sets its bit in `overrun_flags`. A read of the channel clears it.
- R11: `chan_mask` and `clk_div` are used only at conversion boundaries. Changing them during a conversion alters neither its channel nor its length.
- R12: A synchronous active-low reset returns the block to idle from any state. After reset `busy` and `sample_hold` are low, `dac_code` is 0 and all done and overrun flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_mask | input | NCH | Channels to convert, one bit each |
| clk_div | input | DIV_W | Divider value D; conversion period is D+1 clocks |
| burst_en | input | 1 | Repeated scanning of selected channels while high |
| start_once | input | 1 | One-cycle pulse requesting a single conversion |
| comp_in | input | 1 | Comparator: 1 when held input >= trial code |
| sample_hold | output | 1 | High during the sampling period |
| dac_code | output | RES | Trial code to the DAC, 0 when not deciding |
| amux_sel | output | CH_W | Channel currently connected to the converter |
| busy | output | 1 | A conversion is in progress |
| rd_en | input | 1 | Read strobe; clears done and overrun of rd_chan |
| rd_chan | input | CH_W | Channel whose result is presented |
| rd_data | output | RES | Stored result of rd_chan |
| done_flags | output | NCH | Unread-result flag per channel |
| overrun_flags | output | NCH | Overwritten-before-read flag per channel |

## Verification
The bound checker watches the rules that hold on every cycle. These are that sampling only happens while busy, that an idle block drives a zero trial code, that a zero mask never starts a conversion, that a nonzero trial code is driven during every decision, that the channel select holds steady within a conversion, and how done and overrun react to writes and reads. The bench's scenarios are needed for everything that depends on sequences and arithmetic. That covers the exact conversion length for several divider values, the full sweep of input codes against the expected approximation result, the scan order with wrap-around, gap-free back-to-back timing, completion after burst is cleared, and settings changed in the middle of a conversion.

// File: rtl/sar_scan_pkg.sv
// Shared types for the scan sequencer.
// Assumes: single clock domain, used by sar_scan_ctrl and its helpers.
package sar_scan_pkg;

    // Sequencer phase: idle, sampling period, or bit-decision periods.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_DECIDE = 2'd2
    } phase_e;

endpackage

// File: rtl/sar_tick_gen.sv
// Conversion-rate enable generator.
// Produces a one-cycle tick every (div_val+1) clocks while run is high.
// Assumes: div_val changes only in the cycle the counter wraps or while stopped.
module sar_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Count clocks within one conversion period; hold at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div_val) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div_val);

endmodule

// File: rtl/sar_chan_pick.sv
// Next-channel selector for the scan.
// From a start it returns the lowest set mask bit; otherwise the lowest set
// bit above cur_chan, wrapping to the lowest set bit when none is higher.
// Assumes: NCH >= 2; result is meaningful only when any_sel is high.
module sar_chan_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  mask,
    input  logic [CH_W-1:0] cur_chan,
    input  logic            from_start,
    output logic [CH_W-1:0] nxt_chan,
    output logic            any_sel
);

    logic [CH_W-1:0] lowest;
    logic [CH_W-1:0] above;
    logic            have_above;

    // Scan downward so the last hit is the lowest qualifying bit.
    always_comb begin
        lowest     = '0;
        above      = '0;
        have_above = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                lowest = CH_W'(i);
                if (i > int'(cur_chan)) begin
                    above      = CH_W'(i);
                    have_above = 1'b1;
                end
            end
        end
    end

    assign any_sel  = |mask;
    assign nxt_chan = (!from_start && have_above) ? above : lowest;

endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register.
// Holds the bits decided so far; the trial code adds the bit under test.
// On a decision, the tested bit is kept when the comparator reads 1.
// Assumes: clr is held during sampling; bit_idx walks RES-1 down to 0.
module sar_approx #(
    parameter int RES   = 10,
    parameter int BIT_W = $clog2(RES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             decide,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             comp_in,
    output logic [RES-1:0]   trial,
    output logic [RES-1:0]   final_code
);

    logic [RES-1:0] acc_q;
    logic [RES-1:0] bit_mask;

    assign bit_mask   = RES'(1) << bit_idx;
    assign trial      = acc_q | bit_mask;
    assign final_code = comp_in ? trial : acc_q;

    // Accumulate kept bits; a rejected trial bit simply stays zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (decide && comp_in) begin
            acc_q <= acc_q | bit_mask;
        end
    end

endmodule

// File: rtl/sar_result_bank.sv
// Per-channel result storage with done and overrun flags.
// A write sets done; a read clears done and overrun. A write onto an unread
// result (not read in the same cycle) sets overrun.
// Assumes: at most one write and one read per cycle.
module sar_result_bank #(
    parameter int NCH  = 8,
    parameter int RES  = 10,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_chan,
    input  logic [RES-1:0]  wr_data,
    input  logic            rd_en,
    input  logic [CH_W-1:0] rd_chan,
    output logic [RES-1:0]  rd_data,
    output logic [NCH-1:0]  done_flags,
    output logic [NCH-1:0]  overrun_flags
);

    logic [NCH-1:0][RES-1:0] res_all;

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic           wr_hit;
        logic           rd_hit;
        logic [RES-1:0] val_q;
        logic           done_q;
        logic           ovr_q;

        assign wr_hit = wr_en && (wr_chan == CH_W'(g));
        assign rd_hit = rd_en && (rd_chan == CH_W'(g));

        // Update one channel's result and flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q  <= '0;
                done_q <= 1'b0;
                ovr_q  <= 1'b0;
            end else if (wr_hit) begin
                val_q  <= wr_data;
                done_q <= 1'b1;
                ovr_q  <= rd_hit ? 1'b0 : (ovr_q | done_q);
            end else if (rd_hit) begin
                done_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
        end

        assign res_all[g]       = val_q;
        assign done_flags[g]    = done_q;
        assign overrun_flags[g] = ovr_q;
    end

    assign rd_data = res_all[rd_chan];

endmodule

// File: rtl/sar_scan_ctrl.sv
// Scan sequencer for a shared successive-approximation converter.
// Runs one sampling period and RES decision periods per conversion, each
// period lasting (divider+1) clocks, and scans selected channels in burst.
// Assumes: mask and divider are taken only at conversion boundaries;
// the analog front end follows sample_hold, amux_sel and dac_code.
module sar_scan_ctrl #(
    parameter int NCH   = 8,
    parameter int RES   = 10,
    parameter int DIV_W = 8,
    parameter int CH_W  = $clog2(NCH),
    parameter int BIT_W = $clog2(RES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   chan_mask,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             burst_en,
    input  logic             start_once,
    input  logic             comp_in,
    output logic             sample_hold,
    output logic [RES-1:0]   dac_code,
    output logic [CH_W-1:0]  amux_sel,
    output logic             busy,
    input  logic             rd_en,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES-1:0]   rd_data,
    output logic [NCH-1:0]   done_flags,
    output logic [NCH-1:0]   overrun_flags
);
    import sar_scan_pkg::*;

    phase_e           phase_q;
    logic [BIT_W-1:0] bit_q;
    logic [CH_W-1:0]  chan_q;
    logic [DIV_W-1:0] div_q;

    logic             tick;
    logic             run;
    logic [CH_W-1:0]  nxt_chan;
    logic             any_sel;
    logic             last_step;
    logic             res_wr;
    logic [RES-1:0]   trial;
    logic [RES-1:0]   final_code;
    logic             go_now;
    logic             keep_going;

    assign run        = (phase_q != PH_IDLE);
    assign last_step  = (phase_q == PH_DECIDE) && tick && (bit_q == '0);
    assign res_wr     = last_step;
    assign go_now     = (burst_en || start_once) && any_sel;
    assign keep_going = burst_en && any_sel;

    sar_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_val (div_q),
        .tick    (tick)
    );

    sar_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .mask       (chan_mask),
        .cur_chan   (chan_q),
        .from_start (phase_q == PH_IDLE),
        .nxt_chan   (nxt_chan),
        .any_sel    (any_sel)
    );

    sar_approx #(.RES(RES), .BIT_W(BIT_W)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (phase_q == PH_SAMPLE),
        .decide     ((phase_q == PH_DECIDE) && tick),
        .bit_idx    (bit_q),
        .comp_in    (comp_in),
        .trial      (trial),
        .final_code (final_code)
    );

    sar_result_bank #(.NCH(NCH), .RES(RES), .CH_W(CH_W)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (res_wr),
        .wr_chan       (chan_q),
        .wr_data       (final_code),
        .rd_en         (rd_en),
        .rd_chan       (rd_chan),
        .rd_data       (rd_data),
        .done_flags    (done_flags),
        .overrun_flags (overrun_flags)
    );

    // Sequence phases; latch channel and divider only at conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            bit_q   <= '0;
            chan_q  <= '0;
            div_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (go_now) begin
                        phase_q <= PH_SAMPLE;
                        chan_q  <= nxt_chan;
                        div_q   <= clk_div;
                    end
                end
                PH_SAMPLE: begin
                    if (tick) begin
                        phase_q <= PH_DECIDE;
                        bit_q   <= BIT_W'(RES - 1);
                    end
                end
                PH_DECIDE: begin
                    if (tick) begin
                        if (bit_q == '0) begin
                            if (keep_going) begin
                                phase_q <= PH_SAMPLE;
                                chan_q  <= nxt_chan;
                                div_q   <= clk_div;
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end else begin
                            bit_q <= bit_q - 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy        = run;
    assign sample_hold = (phase_q == PH_SAMPLE);
    assign dac_code    = (phase_q == PH_DECIDE) ? trial : '0;
    assign amux_sel    = chan_q;

endmodule

// File: rtl/sar_scan_chk.sv
// Property checker for sar_scan_ctrl, attached by bind below.
// Assumes: reset is asserted for at least one clock at start of run.
module sar_scan_chk #(
    parameter int NCH  = 8,
    parameter int RES  = 10,
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            sample_hold,
    input logic [RES-1:0]  dac_code,
    input logic [CH_W-1:0] amux_sel,
    input logic            burst_en,
    input logic [NCH-1:0]  chan_mask,
    input logic            rd_en,
    input logic [CH_W-1:0] rd_chan,
    input logic            wr_en,
    input logic [CH_W-1:0] wr_chan,
    input logic [NCH-1:0]  done_flags,
    input logic [NCH-1:0]  overrun_flags
);

    logic [CH_W-1:0] rd_chan_d;
    logic [CH_W-1:0] wr_chan_d;

    // Remember last cycle's channel indices for next-cycle checks.
    always_ff @(posedge clk) begin
        rd_chan_d <= rd_chan;
        wr_chan_d <= wr_chan;
    end

    assert_sample_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> busy);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0) && !sample_hold);

    assert_zero_mask_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && burst_en && (chan_mask == '0)) |=> !busy);

    assert_trial_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample_hold) |-> (dac_code != '0));

    assert_chan_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$rose(sample_hold)) |-> $stable(amux_sel));

    assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> done_flags[wr_chan_d]);

    assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(wr_en && (wr_chan == rd_chan))) |=> !done_flags[rd_chan_d]);

    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && done_flags[wr_chan] && !(rd_en && (rd_chan == wr_chan)))
        |=> overrun_flags[wr_chan_d]);

endmodule

bind sar_scan_ctrl sar_scan_chk #(.NCH(NCH), .RES(RES), .CH_W(CH_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .sample_hold   (sample_hold),
    .dac_code      (dac_code),
    .amux_sel      (amux_sel),
    .burst_en      (burst_en),
    .chan_mask     (chan_mask),
    .rd_en         (rd_en),
    .rd_chan       (rd_chan),
    .wr_en         (res_wr),
    .wr_chan       (chan_q),
    .done_flags    (done_flags),
    .overrun_flags (overrun_flags)
);

// File: tb/tb_sar_scan_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: models the analog front end and logs every conversion.
module tb_sar_scan_ctrl;
    localparam int NCH = 8, RES = 10, DIV_W = 8, CH_W = 3;
    localparam int LOGN = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   chan_mask = '0;
    logic [DIV_W-1:0] clk_div = '0;
    logic             burst_en = 1'b0;
    logic             start_once = 1'b0;
    logic             comp_in;
    logic             sample_hold;
    logic [RES-1:0]   dac_code;
    logic [CH_W-1:0]  amux_sel;
    logic             busy;
    logic             rd_en = 1'b0;
    logic [CH_W-1:0]  rd_chan = '0;
    logic [RES-1:0]   rd_data;
    logic [NCH-1:0]   done_flags;
    logic [NCH-1:0]   overrun_flags;

    int vin [NCH];
    int held_v = 0;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    sar_scan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .clk_div(clk_div),
        .burst_en(burst_en), .start_once(start_once), .comp_in(comp_in),
        .sample_hold(sample_hold), .dac_code(dac_code), .amux_sel(amux_sel),
        .busy(busy), .rd_en(rd_en), .rd_chan(rd_chan), .rd_data(rd_data),
        .done_flags(done_flags), .overrun_flags(overrun_flags)
    );

    always #2.5 clk = ~clk;

    // Analog model: hold the selected input while sampling, compare to DAC.
    always @(posedge clk) if (sample_hold) held_v <= vin[amux_sel];
    assign comp_in = (held_v >= int'(dac_code));

    // Conversion log: channel, sampling length and total length of each.
    int  cyc = 0, log_n = 0, start_c = 0;
    int  log_ch [LOGN];
    int  log_sh [LOGN];
    int  log_len [LOGN];
    bit  open_c = 0, prev_sh = 0, prev_busy = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_sh = 0; prev_busy = 0; open_c = 0;
        end else begin
            if (sample_hold && !prev_sh) begin
                if (open_c && log_n > 0) log_len[log_n-1] = cyc - start_c;
                if (log_n < LOGN) begin
                    log_ch[log_n] = int'(amux_sel);
                    log_sh[log_n] = 0;
                    log_len[log_n] = -1;
                    log_n++;
                end
                open_c = 1; start_c = cyc;
            end
            if (sample_hold && log_n > 0) log_sh[log_n-1]++;
            if (!busy && prev_busy && open_c) begin
                log_len[log_n-1] = cyc - start_c;
                open_c = 0;
            end
            prev_sh = sample_hold; prev_busy = busy;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 5000) begin step(1); t++; end
        chk(t < 5000, "R6", "idle timeout", t, 0);
    endtask

    task automatic wait_log(input int n);
        int t = 0;
        while (log_n < n && t < 5000) begin step(1); t++; end
        chk(t < 5000, "R4", "log wait timeout", log_n, n);
    endtask

    task automatic read_ch(input int ch, output int d);
        rd_chan = CH_W'(ch); rd_en = 1'b1;
        #0.5 d = int'(rd_data);
        step(1);
        rd_en = 1'b0;
    endtask

    task automatic pulse_start();
        start_once = 1'b1; step(1); start_once = 1'b0;
    endtask

    function automatic int clampv(input int v);
        return (v > 1023) ? 1023 : v;
    endfunction

    // One single conversion, fully checked.
    task automatic single_conv(input int ch, input int v, input int d);
        int got;
        vin[ch] = v; chan_mask = NCH'(1) << ch; clk_div = DIV_W'(d);
        log_n = 0;
        pulse_start();
        wait_idle();
        chk(log_n == 1, "R8", "conversions", log_n, 1);
        chk(log_ch[0] == ch, "R8", "channel", log_ch[0], ch);
        chk(log_sh[0] == d + 1, "R2", "sample length", log_sh[0], d + 1);
        chk(log_len[0] == 11 * (d + 1), "R1", "conv length", log_len[0], 11 * (d + 1));
        chk(done_flags[ch] == 1'b1, "R9", "done set", int'(done_flags[ch]), 1);
        read_ch(ch, got);
        chk(got == clampv(v), "R3", "result", got, clampv(v));
        chk(done_flags[ch] == 1'b0, "R9", "done cleared", int'(done_flags[ch]), 0);
    endtask

    initial begin : watchdog
        #(5.0 * 190000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL WDOG: got %0d expected %0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int got;
        int seq [4];
        for (int i = 0; i < NCH; i++) vin[i] = 100 * i + 7;
        step(4);
        // R12: reset state
        chk(!busy && !sample_hold, "R12", "busy/sh after reset", int'(busy), 0);
        chk(dac_code == '0, "R12", "dac after reset", int'(dac_code), 0);
        chk(done_flags == '0 && overrun_flags == '0, "R12", "flags after reset",
            int'(done_flags), 0);
        rst_n = 1'b1;
        step(2);

        // R3/R1/R2/R8/R9: exhaustive code sweep at divider 0
        for (int c = 0; c < 1024; c++) single_conv(c % NCH, c, 0);
        // Clamp above full scale and other divider values
        single_conv(3, 1500, 0);
        single_conv(6, 4000, 2);
        for (int d = 1; d < 8; d += 2) begin
            single_conv(d, 37 * d + 511, d);
            single_conv(7 - d, 1023 - 61 * d, d);
        end

        // R8: single start with several channels picks only the lowest
        chan_mask = 8'hA0; clk_div = '0; log_n = 0;
        pulse_start(); wait_idle();
        chk(log_n == 1 && log_ch[0] == 5, "R8", "single multi-mask ch", log_ch[0], 5);
        read_ch(5, got);

        // R4/R5/R6/R10: burst over mask 1,2,5,7 at divider 1, cleared in 5th
        seq[0] = 1; seq[1] = 2; seq[2] = 5; seq[3] = 7;
        for (int i = 0; i < NCH; i++) vin[i] = 90 * i + 13;
        chan_mask = 8'b1010_0110; clk_div = 8'd1; log_n = 0;
        burst_en = 1'b1;
        wait_log(5);
        step(3);
        burst_en = 1'b0;
        wait_idle();
        chk(log_n == 5, "R6", "burst conversions", log_n, 5);
        for (int i = 0; i < 5; i++) begin
            chk(log_ch[i] == seq[i % 4], "R4", "scan order", log_ch[i], seq[i % 4]);
            chk(log_len[i] == 22, "R5", "gap-free length", log_len[i], 22);
        end
        chk(overrun_flags == 8'b0000_0010, "R10", "overrun pattern",
            int'(overrun_flags), 2);
        chk(done_flags == 8'b1010_0110, "R6", "done pattern", int'(done_flags), 8'hA6);
        for (int k = 0; k < 4; k++) begin
            read_ch(seq[k], got);
            chk(got == vin[seq[k]], "R6", "burst result", got, vin[seq[k]]);
        end
        chk(overrun_flags == '0, "R10", "overrun cleared by read", int'(overrun_flags), 0);

        // R7: zero mask in burst, then one-bit mask repeating (R4 wrap)
        chan_mask = '0; clk_div = '0; log_n = 0; burst_en = 1'b1;
        step(40);
        chk(!busy && log_n == 0, "R7", "zero mask idle", log_n, 0);
        pulse_start();
        chk(!busy, "R7", "zero mask start_once", int'(busy), 0);
        chan_mask = 8'h10;
        wait_log(3);
        burst_en = 1'b0;
        wait_idle();
        chk(log_n == 3, "R6", "single-bit burst count", log_n, 3);
        for (int i = 0; i < 3; i++)
            chk(log_ch[i] == 4, "R4", "single-bit wrap", log_ch[i], 4);
        read_ch(4, got);

        // R11: mask and divider changed mid-conversion
        chan_mask = 8'h03; clk_div = 8'd2; log_n = 0; burst_en = 1'b1;
        wait_log(1);
        step(5);
        chan_mask = 8'h0C; clk_div = 8'd0;
        wait_log(3);
        burst_en = 1'b0;
        wait_idle();
        chk(log_ch[0] == 0 && log_len[0] == 33, "R11", "first conv kept",
            log_len[0], 33);
        chk(log_ch[1] == 2 && log_len[1] == 11, "R11", "new mask/div at boundary",
            log_ch[1], 2);
        chk(log_ch[2] == 3, "R11", "next pick", log_ch[2], 3);
        for (int i = 0; i < 4; i++) read_ch(i, got);

        // R12: reset in the middle of a burst
        chan_mask = 8'hFF; clk_div = 8'd1; burst_en = 1'b1;
        step(30);
        rst_n = 1'b0;
        step(1);
        chk(!busy && !sample_hold && dac_code == '0, "R12", "mid-run reset idle",
            int'(busy), 0);
        chk(done_flags == '0 && overrun_flags == '0, "R12", "mid-run reset flags",
            int'(done_flags), 0);
        burst_en = 1'b0;
        rst_n = 1'b1;
        step(2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule